// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block steers the two ALU operand multiplexers of the execute stage in a five-stage integer pipeline. It looks at three instruction words: the consumer held in the ID/EX register, and the two older instructions held in the EX/MEM and MEM/WB registers. For each operand it reports whether the ALU should take the register-file value, the result waiting in MEM/WB, or the result waiting in EX/MEM.

Each older instruction is first classed by its opcode. That class tells whether it writes a register at all, and which field names that register. Register-register ALU operations name their target in a different field from ALU-immediate operations and loads. A load still in EX/MEM has no data yet, so it is never a source. Stalls for that case come from other logic. The selects are purely combinational, so the multiplexers can use them in the same cycle in which the instruction words appear.

Top module: `fwd_select_unit`

## Requirements
- R1: The class of an instruction comes from its opcode, bits [31:26]. 6'h00 is register-register ALU, 6'h08 is ALU-immediate, 6'h23 is load, 6'h2B is store, 6'h04 is branch, and every other opcode is unclassed. A select is 2'b00 for the register file, 2'b01 for MEM/WB and 2'b10 for EX/MEM, and 2'b11 never appears.
- R2: A register-register ALU producer writes the register in bits [15:11]. An ALU-immediate or load producer writes the register in bits [20:16]. The other field of a producer is never matched.
- R3: For a consumer of class register-register ALU, ALU-immediate, load, store or branch, the top select forwards when a producer's written register equals consumer bits [25:21].
- R4: The bottom select forwards only when the consumer is a register-register ALU operation whose bits [20:16] equal a producer's written register. For any other consumer class it stays 2'b00.
- R5: A load in EX/MEM is never a forwarding source. A load in MEM/WB is a forwarding source.
- R6: When EX/MEM and MEM/WB both supply the register an operand needs, that operand selects EX/MEM.
- R7: Store, branch and unclassed producers never cause forwarding, whatever their fields hold.
- R8: A written register of 0 is never forwarded.
- R9: An unclassed consumer gets 2'b00 on both selects.
- R10: The selects hold no state. They follow the present instruction words only, so a new set of words fully sets both selects with no memory of the previous set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| idex_ir | input | 32 | Instruction word of the consumer in ID/EX |
| exmem_ir | input | 32 | Instruction word of the newer producer in EX/MEM |
| memwb_ir | input | 32 | Instruction word of the older producer in MEM/WB |
| sel_top | output | 2 | Source select for the top ALU operand |
| sel_bot | output | 2 | Source select for the bottom ALU operand |

## Verification
Both selects are due in the same cycle in which the three instruction words are applied, because no register lies on any path. The driver changes the words one time unit after a rising edge and queues the two expected selects. The monitor compares them at the next falling edge, so each set of words is checked exactly once and no check depends on the previous set. Sets change every cycle in back-to-back runs to show that nothing carries over.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    localparam int OPC_W = 6;

    typedef enum logic [2:0] {
        CLS_NONE,
        CLS_RR,
        CLS_IMM,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH
    } instr_class_e;

    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_MEMWB   = 2'b01,
        SEL_EXMEM   = 2'b10
    } fwd_sel_e;

    localparam logic [OPC_W-1:0] OPC_RR     = 6'h00;
    localparam logic [OPC_W-1:0] OPC_IMM    = 6'h08;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BRANCH = 6'h04;

    function automatic instr_class_e classify(input logic [OPC_W-1:0] opc);
        instr_class_e c;
        unique case (opc)
            OPC_RR:     c = CLS_RR;
            OPC_IMM:    c = CLS_IMM;
            OPC_LOAD:   c = CLS_LOAD;
            OPC_STORE:  c = CLS_STORE;
            OPC_BRANCH: c = CLS_BRANCH;
            default:    c = CLS_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/fwd_producer_decode.sv
module fwd_producer_decode
    import fwd_pkg::*;
#(
    parameter int REG_W      = 5,
    parameter bit ALLOW_LOAD = 1'b1
) (
    input  logic [OPC_W-1:0] opc,
    input  logic [REG_W-1:0] fld_b,
    input  logic [REG_W-1:0] fld_c,
    output logic             wr_en,
    output logic [REG_W-1:0] dest
);

    instr_class_e cls;
    logic         writes;

    always_comb begin
        cls = classify(opc);
        unique case (cls)
            CLS_RR:   begin writes = 1'b1;       dest = fld_c; end
            CLS_IMM:  begin writes = 1'b1;       dest = fld_b; end
            CLS_LOAD: begin writes = ALLOW_LOAD; dest = fld_b; end
            default:  begin writes = 1'b0;       dest = '0;    end
        endcase
        wr_en = writes && (dest != '0);
    end

    always_comb begin
        if (!$isunknown({opc, fld_b, fld_c})) begin
            // R8
            zero_dest_chk: assert (!(wr_en && dest == '0));
            // R5
            ex_load_blocked_chk: assert (ALLOW_LOAD || cls != CLS_LOAD || !wr_en);
            // R7
            no_write_class_chk: assert (!(wr_en && (cls == CLS_STORE || cls == CLS_BRANCH || cls == CLS_NONE)));
        end
    end

endmodule

// File: rtl/fwd_operand_pick.sv
module fwd_operand_pick
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             use_src,
    input  logic [REG_W-1:0] src,
    input  logic             ex_wr,
    input  logic [REG_W-1:0] ex_dest,
    input  logic             wb_wr,
    input  logic [REG_W-1:0] wb_dest,
    output fwd_sel_e         sel
);

    logic ex_hit;
    logic wb_hit;

    always_comb begin
        ex_hit = use_src && ex_wr && (ex_dest == src);
        wb_hit = use_src && wb_wr && (wb_dest == src);
        if (ex_hit)      sel = SEL_EXMEM;
        else if (wb_hit) sel = SEL_MEMWB;
        else             sel = SEL_REGFILE;
    end

    always_comb begin
        if (!$isunknown({use_src, src, ex_wr, ex_dest, wb_wr, wb_dest})) begin
            // R1
            legal_sel_chk: assert (sel != 2'b11);
            // R6
            newer_wins_chk: assert (!(ex_hit && wb_hit) || sel == SEL_EXMEM);
            // R3
            idle_src_chk: assert (use_src || sel == SEL_REGFILE);
        end
    end

endmodule

// File: rtl/fwd_select_unit.sv
module fwd_select_unit
    import fwd_pkg::*;
#(
    parameter int INSTR_W = 32,
    parameter int REG_W   = 5
) (
    input  logic [INSTR_W-1:0] idex_ir,
    input  logic [INSTR_W-1:0] exmem_ir,
    input  logic [INSTR_W-1:0] memwb_ir,
    output logic [1:0]         sel_top,
    output logic [1:0]         sel_bot
);

    localparam int OPC_LSB = INSTR_W - OPC_W;
    localparam int A_LSB   = OPC_LSB - REG_W;
    localparam int B_LSB   = A_LSB - REG_W;
    localparam int C_LSB   = B_LSB - REG_W;
    localparam int NPROD   = 2;
    localparam int NOPND   = 2;

    logic [INSTR_W-1:0] prod_ir [NPROD];
    logic               prod_wr [NPROD];
    logic [REG_W-1:0]   prod_dst[NPROD];

    assign prod_ir[0] = exmem_ir;
    assign prod_ir[1] = memwb_ir;

    for (genvar p = 0; p < NPROD; p++) begin : g_prod
        fwd_producer_decode #(
            .REG_W      (REG_W),
            .ALLOW_LOAD (p != 0)
        ) u_dec (
            .opc   (prod_ir[p][INSTR_W-1:OPC_LSB]),
            .fld_b (prod_ir[p][A_LSB-1:B_LSB]),
            .fld_c (prod_ir[p][B_LSB-1:C_LSB]),
            .wr_en (prod_wr[p]),
            .dest  (prod_dst[p])
        );
    end

    instr_class_e     cons_cls;
    logic             use_src[NOPND];
    logic [REG_W-1:0] src    [NOPND];
    fwd_sel_e         sel    [NOPND];

    always_comb begin
        cons_cls   = classify(idex_ir[INSTR_W-1:OPC_LSB]);
        use_src[0] = (cons_cls != CLS_NONE);
        use_src[1] = (cons_cls == CLS_RR);
        src[0]     = idex_ir[OPC_LSB-1:A_LSB];
        src[1]     = idex_ir[A_LSB-1:B_LSB];
    end

    for (genvar o = 0; o < NOPND; o++) begin : g_opnd
        fwd_operand_pick #(.REG_W(REG_W)) u_pick (
            .use_src (use_src[o]),
            .src     (src[o]),
            .ex_wr   (prod_wr[0]),
            .ex_dest (prod_dst[0]),
            .wb_wr   (prod_wr[1]),
            .wb_dest (prod_dst[1]),
            .sel     (sel[o])
        );
    end

    assign sel_top = sel[0];
    assign sel_bot = sel[1];

    always_comb begin
        if (!$isunknown({idex_ir, exmem_ir, memwb_ir})) begin
            // R4
            bot_rr_only_chk: assert (sel_bot == 2'b00 || cons_cls == CLS_RR);
            // R9
            unclassed_idle_chk: assert (cons_cls != CLS_NONE || (sel_top == 2'b00 && sel_bot == 2'b00));
        end
    end

endmodule

// File: tb/test_fwd_select_unit.sv
module test_fwd_select_unit;

    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [1:0] t;
        logic [1:0] b;
        string      tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] idex_ir  = '0;
    logic [31:0] exmem_ir = '0;
    logic [31:0] memwb_ir = '0;
    logic [1:0]  sel_top;
    logic [1:0]  sel_bot;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;
    exp_t        q[$];

    fwd_select_unit i_fwd_select_unit (
        .idex_ir  (idex_ir),
        .exmem_ir (exmem_ir),
        .memwb_ir (memwb_ir),
        .sel_top  (sel_top),
        .sel_bot  (sel_bot)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] rr(input logic [4:0] a, b, c);
        return {6'h00, a, b, c, 11'h000};
    endfunction
    function automatic logic [31:0] im(input logic [4:0] a, b, input logic [15:0] k);
        return {6'h08, a, b, k};
    endfunction
    function automatic logic [31:0] ld(input logic [4:0] a, b);
        return {6'h23, a, b, 16'h0040};
    endfunction
    function automatic logic [31:0] st(input logic [4:0] a, b);
        return {6'h2B, a, b, 16'h0010};
    endfunction
    function automatic logic [31:0] br(input logic [4:0] a, b);
        return {6'h04, a, b, 16'h0003};
    endfunction
    function automatic logic [31:0] un(input logic [4:0] a, b, c);
        return {6'h3F, a, b, c, 11'h000};
    endfunction

    task automatic apply(input logic [31:0] c, x, w, input logic [1:0] et, eb, input string tag);
        exp_t e;
        @(posedge clk);
        #1;
        idex_ir  = c;
        exmem_ir = x;
        memwb_ir = w;
        e.t = et;
        e.b = eb;
        e.tag = tag;
        q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (sel_top !== e.t) begin
                errors++;
                $display("FAIL %s sel_top actual %b expected %b", e.tag, sel_top, e.t);
            end
            checks++;
            if (sel_bot !== e.b) begin
                errors++;
                $display("FAIL %s sel_bot actual %b expected %b", e.tag, sel_bot, e.b);
            end
        end
    end

    initial begin
        // reset: all-zero words name register 0 only (R8)
        apply('0, '0, '0, 2'b00, 2'b00, "R8 reset");
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // R3 R2: rr producer in EX/MEM, target in [15:11]
        apply(rr(5, 6, 1), rr(2, 3, 5), '0, 2'b10, 2'b00, "R3");
        // R4: bottom operand of rr consumer
        apply(rr(1, 6, 2), rr(2, 3, 6), '0, 2'b00, 2'b10, "R4");
        // R4: imm consumer ignores its [20:16] field
        apply(im(7, 7, 16'h0), rr(1, 2, 7), '0, 2'b10, 2'b00, "R4 imm consumer");
        // R3: store consumer, MEM/WB source
        apply(st(3, 3), '0, rr(1, 2, 3), 2'b01, 2'b00, "R3 store consumer");
        // R3: branch consumer
        apply(br(12, 12), '0, im(4, 12, 16'h0), 2'b01, 2'b00, "R3 branch consumer");
        // R2: imm producer target in [20:16]; immediate bits [15:11]=4 never matched
        apply(rr(9, 4, 1), im(2, 9, 16'h2000), '0, 2'b10, 2'b00, "R2");
        // R2: rr producer [20:16] field never matched
        apply(rr(3, 1, 2), rr(1, 3, 7), '0, 2'b00, 2'b00, "R2 rr other field");
        // R5: load in EX/MEM blocked, in MEM/WB forwarded
        apply(rr(8, 1, 2), ld(1, 8), '0, 2'b00, 2'b00, "R5 EX/MEM load");
        apply(rr(8, 1, 2), '0, ld(1, 8), 2'b01, 2'b00, "R5 MEM/WB load");
        apply(rr(10, 1, 2), ld(3, 10), im(4, 10, 16'h0), 2'b01, 2'b00, "R5 load over older");
        // R6: both producers hit, EX/MEM wins
        apply(rr(10, 10, 1), rr(1, 2, 10), rr(3, 4, 10), 2'b10, 2'b10, "R6");
        // R6 mixed: top from EX/MEM, bottom from MEM/WB
        apply(rr(1, 2, 3), rr(4, 5, 1), ld(6, 2), 2'b10, 2'b01, "R6 mixed");
        // R7: store / branch / unclassed producers never forward
        apply(rr(11, 11, 1), st(2, 11), br(3, 11), 2'b00, 2'b00, "R7");
        apply(rr(11, 13, 1), un(1, 11, 13), un(1, 13, 11), 2'b00, 2'b00, "R7 unclassed");
        // R8: register 0 never forwarded
        apply(rr(0, 0, 1), rr(1, 2, 0), im(3, 0, 16'h0), 2'b00, 2'b00, "R8");
        // R9: unclassed consumer
        apply(un(5, 6, 1), rr(1, 2, 5), rr(1, 2, 6), 2'b00, 2'b00, "R9");
        // R1: opcode decides class; same fields under load vs rr opcode
        apply(ld(20, 21), rr(1, 2, 20), '0, 2'b10, 2'b00, "R1 load consumer");
        // R10: back-to-back changes every cycle
        apply(rr(14, 15, 1), rr(1, 2, 14), rr(1, 2, 15), 2'b10, 2'b01, "R10 a");
        apply(rr(14, 15, 1), '0, '0, 2'b00, 2'b00, "R10 b");
        apply(rr(14, 15, 1), rr(1, 2, 15), rr(1, 2, 14), 2'b01, 2'b10, "R10 c");
        apply(im(31, 31, 16'h0), rr(1, 2, 31), '0, 2'b10, 2'b00, "R10 d");
        repeat (2) @(posedge clk);
        if (q.size() != 0) begin
            errors++;
            $display("FAIL R10 pending results actual %0d expected 0", q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            errors++;
            $display("FAIL R10 watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule